// File: doc/BRIEF.md
# Register read data multiplexer

This block turns a read address into the data word and the read-ok flag of one register in a register map. It is purely combinational. A register can be wider than the bus word. Such a register spans several consecutive word addresses, and each word address returns one piece of the register. A piece that is narrower than the bus word comes out with zeros in its upper bits.

Registers that need to know when they are being read get a one-hot read-select bit for the addressed word. An address that matches no register passes a secondary data/ok pair through unchanged. That pair normally comes from another read mux further down the chain.

A parameter selects a control-register flavour. In that flavour, unmatched addresses return zero with ok low, and registers flagged write-only read back as zero with ok low.

Top module: `regrd_mux`

## Requirements
- R1: The address is a byte address. Bits [AREA_LOG2-1:log2(DW/8)] index the word inside the area. With GATE_EN set, bits [ADDR_W-1:AREA_LOG2] must equal AREA_BASE, or no register matches. The defaults are DW=16, ADDR_W=8, AREA_LOG2=5 and AREA_BASE=3, so an address is in the area when addr[7:5]==3, and the word index is addr[4:1].
- R2: Register r occupies word addresses REG_BASE[r] to REG_BASE[r]+REG_NWORDS[r]-1. Its contents sit in reg_data[r*RMAX +: RMAX], where RMAX=DW*MAXW. Word i of register r returns the register bits starting at i*P, where P = REG_WIDTH[r]/REG_NWORDS[r] is the piece width.
- R3: A piece narrower than DW is zero-extended into the upper bits of rd_data.
- R4: For a matched word, rd_ok equals reg_ok[r] when bit r of REG_MUXED is set, and 1 otherwise.
- R5: rd_sel bit r*MAXW+i is 1 only when word i of register r is addressed and bit r of REG_HAS_SEL is set. All other rd_sel bits are 0.
- R6: With CREG_MODE=0, an unmatched address passes fb_data and fb_ok through unchanged. So does any address outside the area.
- R7: With CREG_MODE=1, an unmatched address returns data 0 with ok 0. A matched register flagged in REG_WO also returns data 0 with ok 0, though its read-select bit still follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_addr | input | ADDR_W | Read byte address |
| reg_data | input | NREG*RMAX | Register contents, one RMAX-bit slot per register |
| reg_ok | input | NREG | Per-register ok qualifier |
| fb_data | input | DW | Fallback read data |
| fb_ok | input | 1 | Fallback read ok |
| rd_data | output | DW | Selected read data |
| rd_ok | output | 1 | Selected read ok |
| rd_sel | output | NREG*MAXW | Per-word read selects |

## Verification
Every result is combinational, so rd_data, rd_ok and rd_sel are due in the same cycle as the address and contents that produce them, with no register on the path. The bench changes inputs on the rising edge and samples on the following falling edge. Its behavioural model therefore sees settled values. It sweeps all 256 addresses several times with different content and qualifier patterns, comparing both the pass-through flavour and the control-register flavour.

// File: rtl/regrd_mux.sv
module regrd_mux #(
  parameter int DW         = 16,
  parameter int ADDR_W     = 8,
  parameter int AREA_LOG2  = 5,
  parameter int GATE_EN    = 1,
  parameter int AREA_BASE  = 3,
  parameter int NREG       = 4,
  parameter int MAXW       = 2,
  parameter int CREG_MODE  = 0,
  parameter logic [NREG*8-1:0] REG_BASE   = {8'd9, 8'd5, 8'd2, 8'd0},
  parameter logic [NREG*8-1:0] REG_WIDTH  = {8'd32, 8'd8, 8'd24, 8'd16},
  parameter logic [NREG*8-1:0] REG_NWORDS = {8'd2, 8'd1, 8'd2, 8'd1},
  parameter logic [NREG-1:0]   REG_MUXED  = 4'b1010,
  parameter logic [NREG-1:0]   REG_HAS_SEL = 4'b0011,
  parameter logic [NREG-1:0]   REG_WO     = 4'b0100,
  localparam int RMAX = DW * MAXW
) (
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NREG*RMAX-1:0] reg_data,
  input  logic [NREG-1:0]      reg_ok,
  input  logic [DW-1:0]        fb_data,
  input  logic                 fb_ok,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_ok,
  output logic [NREG*MAXW-1:0] rd_sel
);
  localparam int WOB  = $clog2(DW / 8);
  localparam int IDXW = AREA_LOG2 - WOB;
  localparam int TAGW = ADDR_W - AREA_LOG2;

  logic            in_area;
  logic [IDXW-1:0] idx;
  logic            hit;
  int              hit_pw;

  assign in_area = (GATE_EN == 0) || (rd_addr[ADDR_W-1:AREA_LOG2] == TAGW'(AREA_BASE));
  assign idx     = rd_addr[AREA_LOG2-1:WOB];

  always_comb begin
    logic [RMAX-1:0] piece, mask;
    int pw;
    rd_sel = '0;
    hit    = 1'b0;
    hit_pw = DW;
    piece  = '0;
    mask   = '0;
    pw     = DW;
    if (CREG_MODE != 0) begin
      rd_data = '0;
      rd_ok   = 1'b0;
    end else begin
      rd_data = fb_data;
      rd_ok   = fb_ok;
    end
    if (in_area) begin
      for (int r = 0; r < NREG; r++) begin
        for (int i = 0; i < MAXW; i++) begin
          if (!hit && i < int'(REG_NWORDS[r*8 +: 8]) &&
              idx == IDXW'(int'(REG_BASE[r*8 +: 8]) + i)) begin
            hit    = 1'b1;
            pw     = int'(REG_WIDTH[r*8 +: 8]) / int'(REG_NWORDS[r*8 +: 8]);
            hit_pw = pw;
            mask   = (RMAX'(1) << pw) - RMAX'(1);
            piece  = (reg_data[r*RMAX +: RMAX] >> (i * pw)) & mask;
            rd_data = piece[DW-1:0];
            rd_ok   = REG_MUXED[r] ? reg_ok[r] : 1'b1;
            if (CREG_MODE != 0 && REG_WO[r]) begin
              rd_data = '0;
              rd_ok   = 1'b0;
            end
            if (REG_HAS_SEL[r]) rd_sel[r*MAXW + i] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    p_sel_onehot_r5: assert ($onehot0(rd_sel));
    p_sel_in_area_r1: assert (!(|rd_sel) || in_area);
    if (hit && hit_pw < DW)
      p_zero_ext_r3: assert ((rd_data >> hit_pw) == '0);
    if (CREG_MODE == 0 && !in_area)
      p_fallthrough_r6: assert (rd_data == fb_data && rd_ok == fb_ok);
    if (CREG_MODE != 0 && !in_area)
      p_creg_default_r7: assert (rd_data == '0 && !rd_ok);
  end
endmodule

// File: tb/regrd_mux_test.sv
module regrd_mux_test;
  localparam int DW = 16, NREG = 4, MAXW = 2, RMAX = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]           rd_addr  = 8'h00;
  logic [NREG*RMAX-1:0] reg_data = '0;
  logic [NREG-1:0]      reg_ok   = '0;
  logic [DW-1:0]        fb_data  = '0;
  logic                 fb_ok    = 1'b0;
  logic [DW-1:0]        d0, d1;
  logic                 o0, o1;
  logic [NREG*MAXW-1:0] s0, s1;

  regrd_mux uut (.rd_addr(rd_addr), .reg_data(reg_data), .reg_ok(reg_ok),
    .fb_data(fb_data), .fb_ok(fb_ok), .rd_data(d0), .rd_ok(o0), .rd_sel(s0));
  regrd_mux #(.CREG_MODE(1)) uut_creg (.rd_addr(rd_addr), .reg_data(reg_data),
    .reg_ok(reg_ok), .fb_data(fb_data), .fb_ok(fb_ok), .rd_data(d1),
    .rd_ok(o1), .rd_sel(s1));

  int base  [NREG] = '{0, 2, 5, 9};
  int width [NREG] = '{16, 24, 8, 32};
  int nw    [NREG] = '{1, 2, 1, 2};
  bit muxed [NREG] = '{0, 1, 0, 1};
  bit hassel[NREG] = '{1, 1, 0, 0};
  bit wo    [NREG] = '{0, 0, 1, 0};

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic model(input bit creg, output logic [DW-1:0] ed, output logic eo,
                       output logic [NREG*MAXW-1:0] es, output string tag);
    int w;
    bit found;
    longint slot, pw;
    found = 0;
    es = '0;
    ed = creg ? '0 : fb_data;
    eo = creg ? 1'b0 : fb_ok;
    tag = creg ? "R7" : (rd_addr[7:5] == 3'd3 ? "R6" : "R1");
    if (rd_addr[7:5] == 3'd3) begin
      w = int'(rd_addr[4:1]);
      for (int r = 0; r < NREG; r++)
        for (int i = 0; i < nw[r]; i++)
          if (!found && w == base[r] + i) begin
            found = 1;
            pw = width[r] / nw[r];
            slot = longint'(reg_data[r*RMAX +: RMAX]);
            ed = DW'((slot >> (i * pw)) & ((64'd1 << pw) - 1));
            eo = muxed[r] ? reg_ok[r] : 1'b1;
            tag = pw < DW ? "R3" : (muxed[r] ? "R4" : "R2");
            if (hassel[r]) begin es[r*MAXW + i] = 1'b1; tag = "R5"; end
            if (creg && wo[r]) begin ed = '0; eo = 1'b0; tag = "R7"; end
          end
    end
  endtask

  task automatic compare(input bit creg);
    logic [DW-1:0] ed; logic eo; logic [NREG*MAXW-1:0] es; string tag;
    logic [DW-1:0] ad; logic ao; logic [NREG*MAXW-1:0] as_;
    model(creg, ed, eo, es, tag);
    ad = creg ? d1 : d0; ao = creg ? o1 : o0; as_ = creg ? s1 : s0;
    checks++;
    if (ad !== ed || ao !== eo || as_ !== es) begin
      fails++;
      $display("FAIL %s addr=%h creg=%0d actual data=%h ok=%b sel=%b expected data=%h ok=%b sel=%b",
               tag, rd_addr, creg, ad, ao, as_, ed, eo, es);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R6, R7: with all inputs zero and the address outside the area
    @(negedge clk);
    compare(0); compare(1);
    for (int pass = 0; pass < 4; pass++) begin
      @(posedge clk);
      case (pass)
        0: begin reg_data = {4{32'hFFFF_FFFF}}; reg_ok = 4'b1111; fb_data = 16'hA5A5; fb_ok = 1; end
        1: begin reg_data = {32'h1234_5678, 32'h0000_00C3, 32'h00AB_CDEF, 32'h0000_BEEF}; reg_ok = 4'b0000; fb_data = 16'h5A5A; fb_ok = 0; end
        default: begin
          for (int k = 0; k < NREG; k++) reg_data[k*RMAX +: RMAX] = $urandom;
          reg_ok = 4'($urandom); fb_data = 16'($urandom); fb_ok = 1'($urandom);
        end
      endcase
      for (int a = 0; a < 256; a++) begin
        @(posedge clk);
        rd_addr = 8'(a);
        if (a[0]) reg_ok = ~reg_ok;
        @(negedge clk);
        compare(0);
        compare(1);
      end
    end
    done = 1;
    finish_run();
  end
endmodule